// File: doc/BRIEF.md
# Vector Gather and Conditional Move Unit

This unit moves elements between vector registers under the control of a third vector. In gather mode, each element of a control vector selects which element of the source vector lands in the matching slot of the destination. In conditional-move mode, each control element acts as a signed predicate. A source element is copied only where its predicate is strictly positive. The same pass also builds a bit mask of the positions that passed.

The unit sits beside a vector register file. It reaches that file through two combinational read ports, one for the control vector and one for the source vector, and through one write port for the destination. A single start pulse launches a run of up to 64 elements, with the length given by a length input. Reads and writes are pipelined over two stages, so the unit sustains one element per clock. A one-cycle done pulse marks the end of each run.

Top module: `vec_gather_cmove`

## Requirements
- R1: In gather mode (`op_cmove`=0), for every i below the run length the destination element i receives the source element whose number is bits [5:0] of control element i.
- R2: `range_err` is cleared by every accepted start. During a gather it is set when any control element i below the run length has a nonzero value in bits [63:6]. A conditional move never sets it.
- R3: In conditional-move mode (`op_cmove`=1), destination element i receives source element i only when control element i, read as a signed 64-bit two's complement value, is greater than zero. For zero or negative control values, no write is made.
- R4: `mask_out` is cleared by every accepted start. After a conditional move, bit i is 1 exactly when i is below the run length and control element i is greater than zero. After a gather it stays all zero.
- R5: Destination elements at or above the run length, and elements not selected, are never written. Writes occur in ascending element order.
- R6: For a run length L above zero there is one write per cycle. `done` goes high for exactly one cycle, L+1 cycles after the edge that accepts start. For L of zero, `done` is high right after the accepting edge and no write occurs.
- R7: A length input above 64 is treated as 64.
- R8: A start pulse while `busy` is high is ignored. The running operation, its op and its length are unaffected.
- R9: After reset, `busy`, `done`, `dst_wr_en`, `range_err` and `mask_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted when not busy |
| op_cmove | input | 1 | 0 = gather, 1 = conditional move |
| vlen | input | 7 | Run length, clamped to 64 |
| idx_rd_elem | output | 6 | Element number on the control-vector read port |
| idx_rd_data | input | 64 | Control element read data (same cycle) |
| src_rd_elem | output | 6 | Element number on the source-vector read port |
| src_rd_data | input | 64 | Source element read data (same cycle) |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_elem | output | 6 | Destination element number |
| dst_wr_data | output | 64 | Destination write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mask_out | output | 64 | Predicate mask from the last conditional move |
| range_err | output | 1 | Out-of-range index seen in the last gather |

## Verification
The bench checks several index cases. Indices with high bits set must wrap to their low six bits. A design that compared the whole word would fetch the wrong element or never raise the flag. Out-of-range indices placed beyond the run length must not raise the flag, which catches a design that scans all 64 elements.

For predicates, the bench uses zero, the most negative value and the most positive value. An unsigned or greater-or-equal compare would show up as wrongly written elements or wrong mask bits.

The bench also covers a zero length, a clamped length of 100, and a start pulse issued mid-run. An off-by-one counter, a missing clamp or a restartable sequencer would produce a changed cycle count, extra writes or corrupted results.

// File: rtl/vec_gather_cmove.sv
module vec_gather_cmove #(
  parameter int NELEM = 64,
  parameter int DW    = 64,
  localparam int EW   = $clog2(NELEM),
  localparam int LW   = EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_cmove,
  input  logic [LW-1:0] vlen,
  output logic [EW-1:0] idx_rd_elem,
  input  logic [DW-1:0] idx_rd_data,
  output logic [EW-1:0] src_rd_elem,
  input  logic [DW-1:0] src_rd_data,
  output logic          dst_wr_en,
  output logic [EW-1:0] dst_wr_elem,
  output logic [DW-1:0] dst_wr_data,
  output logic          busy,
  output logic          done,
  output logic [NELEM-1:0] mask_out,
  output logic          range_err
);

  logic          run, op_q, s1_v, s1_pass, s1_oor, s1_last;
  logic [LW-1:0] cnt, vl_q, vl_eff;
  logic [EW-1:0] s1_elem, s1_idx;
  logic          accept, last_issue;

  assign vl_eff     = (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;
  assign busy       = run | s1_v;
  assign accept     = start & ~busy;
  assign last_issue = (cnt == vl_q - LW'(1));

  assign idx_rd_elem = cnt[EW-1:0];
  assign src_rd_elem = op_q ? s1_elem : s1_idx;
  assign dst_wr_en   = s1_v & (~op_q | s1_pass);
  assign dst_wr_elem = s1_elem;
  assign dst_wr_data = src_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      vl_q <= '0;
      op_q <= 1'b0;
    end else if (accept) begin
      run  <= (vl_eff != '0);
      cnt  <= '0;
      vl_q <= vl_eff;
      op_q <= op_cmove;
    end else if (run) begin
      cnt <= cnt + LW'(1);
      if (last_issue) run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_elem <= '0;
      s1_idx  <= '0;
      s1_pass <= 1'b0;
      s1_oor  <= 1'b0;
      s1_last <= 1'b0;
    end else begin
      s1_v    <= run;
      s1_elem <= cnt[EW-1:0];
      s1_idx  <= idx_rd_data[EW-1:0];
      s1_pass <= $signed(idx_rd_data) > 0;
      s1_oor  <= |idx_rd_data[DW-1:EW];
      s1_last <= last_issue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_out  <= '0;
      range_err <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= (accept && vl_eff == '0) || (s1_v && s1_last);
      if (accept) begin
        mask_out  <= '0;
        range_err <= 1'b0;
      end else if (s1_v) begin
        if (op_q && s1_pass) mask_out[s1_elem] <= 1'b1;
        if (!op_q && s1_oor) range_err <= 1'b1;
      end
    end
  end

  p_wr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> ({1'b0, dst_wr_elem} < vl_q));

  p_wr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && $past(dst_wr_en)) |-> (dst_wr_elem == $past(dst_wr_elem) + EW'(1)));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(start));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vl_q) && $stable(op_q));

  p_gather_nomask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_q) |-> (mask_out == '0));

  p_cmove_noerr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q) |-> !range_err);

endmodule

// File: tb/vec_gather_cmove_tb.sv
module vec_gather_cmove_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_cmove = 1'b0;
  logic [6:0]  vlen = '0;
  logic [5:0]  idx_rd_elem, src_rd_elem, dst_wr_elem;
  logic [63:0] idx_rd_data, src_rd_data, dst_wr_data;
  logic        dst_wr_en, busy, done, range_err;
  logic [63:0] mask_out;

  logic [63:0] amem [64];
  logic [63:0] bmem [64];
  logic [63:0] cmem [64];
  int n_chk = 0, n_fail = 0, n_wr = 0;

  always #(PERIOD/2) clk = ~clk;

  assign idx_rd_data = bmem[idx_rd_elem];
  assign src_rd_data = amem[src_rd_elem];

  always @(posedge clk) if (dst_wr_en) begin
    cmem[dst_wr_elem] <= dst_wr_data;
    n_wr <= n_wr + 1;
  end

  vec_gather_cmove dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cmove(op_cmove), .vlen(vlen),
    .idx_rd_elem(idx_rd_elem), .idx_rd_data(idx_rd_data),
    .src_rd_elem(src_rd_elem), .src_rd_data(src_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_elem(dst_wr_elem), .dst_wr_data(dst_wr_data),
    .busy(busy), .done(done), .mask_out(mask_out), .range_err(range_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sentinel(input int i);
    return 64'hDEAD_0000_0000_0000 | 64'(i);
  endfunction

  task automatic prep();
    for (int i = 0; i < 64; i++) begin
      amem[i] = 64'hA5A5_0000_0000_0000 | 64'(i * 7 + 3);
      cmem[i] = sentinel(i);
    end
  endtask

  task automatic launch(input bit op, input int vl);
    @(negedge clk);
    start = 1'b1; op_cmove = op; vlen = 7'(vl);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(inout int cycles);
    while (!done && cycles < 400) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !dst_wr_en, "R9", "control outputs after reset",
        {61'd0, busy, done, dst_wr_en}, 64'd0);
    chk(mask_out == 64'd0, "R9", "mask after reset", mask_out, 64'd0);
    chk(!range_err, "R9", "range flag after reset", 64'(range_err), 64'd0);
  endtask

  task automatic t_gather_full();
    int cyc = 1, bad = 0, w0;
    prep();
    for (int i = 0; i < 64; i++) bmem[i] = 64'((i * 37 + 5) % 64);
    w0 = n_wr;
    launch(1'b0, 64);
    wait_done(cyc);
    chk(cyc == 66, "R6", "gather 64 cycle count", 64'(cyc), 64'd66);
    @(negedge clk);
    chk(!done, "R6", "done single cycle", 64'(done), 64'd0);
    chk(n_wr - w0 == 64, "R6", "gather 64 write count", 64'(n_wr - w0), 64'd64);
    for (int i = 0; i < 64; i++) if (cmem[i] !== amem[bmem[i][5:0]]) bad++;
    chk(bad == 0, "R1", "gather 64 mismatching elements", 64'(bad), 64'd0);
    chk(!range_err, "R2", "no range flag for small indices", 64'(range_err), 64'd0);
    chk(mask_out == 64'd0, "R4", "mask zero after gather", mask_out, 64'd0);
  endtask

  task automatic t_gather_partial();
    int cyc = 1, bad = 0;
    prep();
    for (int i = 0; i < 64; i++) bmem[i] = 64'(63 - i);
    bmem[20] = 64'd500;
    launch(1'b0, 5);
    wait_done(cyc);
    chk(cyc == 7, "R6", "gather 5 cycle count", 64'(cyc), 64'd7);
    for (int i = 0; i < 5; i++) if (cmem[i] !== amem[63 - i]) bad++;
    chk(bad == 0, "R1", "gather 5 mismatching elements", 64'(bad), 64'd0);
    bad = 0;
    for (int i = 5; i < 64; i++) if (cmem[i] !== sentinel(i)) bad++;
    chk(bad == 0, "R5", "elements beyond length touched", 64'(bad), 64'd0);
    chk(!range_err, "R2", "index beyond length ignored", 64'(range_err), 64'd0);
  endtask

  task automatic t_gather_oor();
    int cyc = 1, bad = 0;
    prep();
    for (int i = 0; i < 64; i++) bmem[i] = 64'(i + 1);
    bmem[3] = 64'd74;
    bmem[6] = 64'hFFFF_FFFF_FFFF_FFFF;
    launch(1'b0, 8);
    wait_done(cyc);
    chk(cmem[3] === amem[10], "R1", "index 74 wraps to 10", cmem[3], amem[10]);
    chk(cmem[6] === amem[63], "R1", "index -1 wraps to 63", cmem[6], amem[63]);
    for (int i = 0; i < 8; i++) if (i != 3 && i != 6 && cmem[i] !== amem[i + 1]) bad++;
    chk(bad == 0, "R1", "other gathered elements", 64'(bad), 64'd0);
    chk(range_err, "R2", "range flag set", 64'(range_err), 64'd1);
  endtask

  task automatic t_cmove();
    int cyc = 1, bad = 0, w0;
    logic [63:0] em = '0;
    prep();
    for (int i = 0; i < 64; i++)
      case (i % 4)
        0: bmem[i] = 64'd0;
        1: bmem[i] = 64'(i + 100);
        2: bmem[i] = 64'h8000_0000_0000_0000;
        default: bmem[i] = 64'h7FFF_FFFF_FFFF_FFFF;
      endcase
    bmem[9] = 64'h0000_0100_0000_0000;
    for (int i = 0; i < 40; i++) if ($signed(bmem[i]) > 0) em[i] = 1'b1;
    w0 = n_wr;
    launch(1'b1, 40);
    wait_done(cyc);
    chk(cyc == 42, "R6", "cmove 40 cycle count", 64'(cyc), 64'd42);
    chk(n_wr - w0 == 20, "R3", "cmove write count", 64'(n_wr - w0), 64'd20);
    for (int i = 0; i < 64; i++)
      if (cmem[i] !== ((i < 40 && $signed(bmem[i]) > 0) ? amem[i] : sentinel(i))) bad++;
    chk(bad == 0, "R3", "cmove mismatching elements", 64'(bad), 64'd0);
    chk(mask_out == em, "R4", "cmove mask", mask_out, em);
    chk(!range_err, "R2", "cmove never flags range", 64'(range_err), 64'd0);
  endtask

  task automatic t_vl_zero();
    int cyc = 1, w0;
    prep();
    w0 = n_wr;
    launch(1'b1, 0);
    chk(done, "R6", "done right after zero-length start", 64'(done), 64'd1);
    wait_done(cyc);
    @(negedge clk);
    chk(n_wr == w0, "R6", "zero length writes", 64'(n_wr - w0), 64'd0);
    chk(mask_out == 64'd0, "R4", "mask cleared by start", mask_out, 64'd0);
  endtask

  task automatic t_clamp();
    int cyc = 1, w0, bad = 0;
    prep();
    for (int i = 0; i < 64; i++) bmem[i] = 64'(i ^ 6'h2A);
    w0 = n_wr;
    launch(1'b0, 100);
    wait_done(cyc);
    chk(cyc == 66, "R7", "length 100 cycle count", 64'(cyc), 64'd66);
    chk(n_wr - w0 == 64, "R7", "length 100 write count", 64'(n_wr - w0), 64'd64);
    for (int i = 0; i < 64; i++) if (cmem[i] !== amem[i ^ 6'h2A]) bad++;
    chk(bad == 0, "R7", "clamped gather elements", 64'(bad), 64'd0);
  endtask

  task automatic t_busy_start();
    int cyc = 1, w0, bad = 0;
    prep();
    for (int i = 0; i < 64; i++) bmem[i] = 64'((i + 9) % 64);
    w0 = n_wr;
    launch(1'b0, 10);
    @(negedge clk); cyc++;
    start = 1'b1; op_cmove = 1'b1; vlen = 7'd2;
    @(negedge clk); cyc++;
    start = 1'b0; op_cmove = 1'b0;
    wait_done(cyc);
    chk(cyc == 12, "R8", "cycle count with ignored start", 64'(cyc), 64'd12);
    chk(n_wr - w0 == 10, "R8", "write count with ignored start", 64'(n_wr - w0), 64'd10);
    for (int i = 0; i < 10; i++) if (cmem[i] !== amem[(i + 9) % 64]) bad++;
    chk(bad == 0, "R8", "gather result kept", 64'(bad), 64'd0);
    chk(mask_out == 64'd0, "R8", "no cmove mask", mask_out, 64'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    prep();
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_gather_full();
    t_gather_partial();
    t_gather_oor();
    t_cmove();
    t_vl_zero();
    t_clamp();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule